// File: doc/BRIEF.md
# Carry-Select Adder

A purely combinational binary adder that adds two unsigned operands and a carry input. The lowest section is an ordinary ripple adder fed by the real carry input. Every higher section holds two copies of its adder. One copy assumes an incoming carry of zero and the other assumes one. Both copies settle while the lower sections are still working. The carry that finally arrives from below only steers a row of 2:1 multiplexers. Those multiplexers pick that section's sum bits and its outgoing carry.

The default build is 8 bits wide and split into two 4-bit sections. It has a 4-bit ripple stage over bits 3..0, followed by one dual-adder stage over bits 7..4. Width and section size are parameters, so the same code builds a chain of several select stages. The block fits where a plain ripple chain is too slow for the whole word and full lookahead costs too much logic.

Top module: `csel_adder`

## Requirements
- R1: `sum` equals the low 8 bits of the unsigned total `opa + opb + cin`.
- R2: `cout` equals bit 8 of the unsigned total `opa + opb + cin`.
- R3: `sum[3:0]` equals the low 4 bits of `opa[3:0] + opb[3:0] + cin`. It depends on no upper operand bit.
- R4: When the lower section's carry is 0, meaning `opa[3:0] + opb[3:0] + cin` < 16, `{cout, sum[7:4]}` equals `opa[7:4] + opb[7:4]`.
- R5: When the lower section's carry is 1, meaning `opa[3:0] + opb[3:0] + cin` >= 16, `{cout, sum[7:4]}` equals `opa[7:4] + opb[7:4] + 1`.
- R6: When every upper bit pair propagates, meaning `opa[7:4] ^ opb[7:4]` = 4'hF, `cout` equals the lower section's carry and `sum[7:4]` equals its inverse on all four bits.
- R7: A carry entering a fully propagating word travels to the top. For example, `opa`=8'hFF, `opb`=8'h00, `cin`=1 gives `sum`=8'h00, `cout`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa  | input  | 8 | First operand |
| opb  | input  | 8 | Second operand |
| cin  | input  | 1 | Carry into bit 0 |
| sum  | output | 8 | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is a carry that is born in the lower section and arrives at a fully propagating upper section. Only that case makes the selected candidate differ from its alternative in every bit, including the outgoing carry. Because the default build has just 17 input bits, the stimulus walks all 131072 combinations of both operands and the carry input. Every such case is therefore visited, and each vector is also sorted by its lower-section carry so that both multiplexer settings are checked.

// File: rtl/csel_pkg.sv
package csel_pkg;
  // one-bit full adder, result is {carry, sum}
  function automatic logic [1:0] fa(input logic x, input logic y, input logic c);
    fa = {(x & y) | (c & (x ^ y)), x ^ y ^ c};
  endfunction
endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] chain;
  assign chain[0] = ci;
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] r;
    assign r          = csel_pkg::fa(a[i], b[i], chain[i]);
    assign s[i]       = r[0];
    assign chain[i+1] = r[1];
  end
  assign co = chain[W];

  logic [W:0] arith_total;
  assign arith_total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
  always_comb begin
    p_ripple_total_r3: assert ({co, s} == arith_total)
      else $error("ripple section total wrong");
  end
endmodule

// File: rtl/csel_section.sv
module csel_section #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_c,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0] s_zero, s_one;
  logic         c_zero, c_one;

  csel_ripple #(.W(W)) i_assume0 (.a(a), .b(b), .ci(1'b0), .s(s_zero), .co(c_zero));
  csel_ripple #(.W(W)) i_assume1 (.a(a), .b(b), .ci(1'b1), .s(s_one),  .co(c_one));

  for (genvar i = 0; i < W; i++) begin : g_mux
    assign s[i] = sel_c ? s_one[i] : s_zero[i];
  end
  assign co = sel_c ? c_one : c_zero;

  always_comb begin
    p_cand_step_r5: assert ({c_one, s_one} == {c_zero, s_zero} + 1'b1)
      else $error("carry-one candidate is not candidate-zero plus one");
    if (!sel_c) begin
      p_pick_zero_r4: assert ({co, s} == {c_zero, s_zero})
        else $error("wrong candidate with select low");
    end else begin
      p_pick_one_r5: assert ({co, s} == {c_one, s_one})
        else $error("wrong candidate with select high");
    end
  end
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int WIDTH = 8,
  parameter int SECT  = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NSEC = WIDTH / SECT;

  logic [NSEC:0] sec_carry;
  assign sec_carry[0] = cin;

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    if (k == 0) begin : g_low
      csel_ripple #(.W(SECT)) i_low (
        .a(opa[SECT-1:0]), .b(opb[SECT-1:0]), .ci(sec_carry[0]),
        .s(sum[SECT-1:0]), .co(sec_carry[1]));
    end else begin : g_sel
      csel_section #(.W(SECT)) i_hi (
        .a(opa[k*SECT +: SECT]), .b(opb[k*SECT +: SECT]), .sel_c(sec_carry[k]),
        .s(sum[k*SECT +: SECT]), .co(sec_carry[k+1]));
    end
  end
  assign cout = sec_carry[NSEC];

  logic [WIDTH:0] word_total;
  assign word_total = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
  always_comb begin
    p_word_sum_r1: assert (sum == word_total[WIDTH-1:0])
      else $error("sum wrong");
    p_word_carry_r2: assert (cout == word_total[WIDTH])
      else $error("carry out wrong");
  end
endmodule

// File: tb/test_csel_adder.sv
module test_csel_adder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] opa, opb, sum;
  logic       cin, cout;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  csel_adder i_csel_adder (.opa(opa), .opb(opb), .cin(cin), .sum(sum), .cout(cout));

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s a=%h b=%h c=%0d actual=%h expected=%h", req, opa, opb, cin, act, exp);
    end
  endtask

  initial begin
    opa = 0; opb = 0; cin = 0;
    for (int v = 0; v < 131072; v++) begin
      @(negedge clk);
      opa = v[7:0]; opb = v[15:8]; cin = v[16];
      #1;
      begin
        int tot, lo, hi;
        tot = opa + opb + cin;
        lo  = opa[3:0] + opb[3:0] + cin;
        hi  = opa[7:4] + opb[7:4];
        chk("R1", sum, tot & 255);
        chk("R2", cout, tot >> 8);
        chk("R3", sum[3:0], lo & 15);
        if (lo < 16) chk("R4", {cout, sum[7:4]}, hi);
        else         chk("R5", {cout, sum[7:4]}, hi + 1);
        if ((opa[7:4] ^ opb[7:4]) == 4'hF) begin
          chk("R6 carry", cout, lo >> 4);
          chk("R6 sum", sum[7:4], (lo >= 16) ? 0 : 15);
        end
        if (opa == 8'hFF && opb == 8'h00 && cin) chk("R7", {cout, sum}, 9'h100);
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule